// File: doc/BRIEF.md
# Sequence-Number Squash Walker

This block keeps a small ring of instruction-queue records. Each record holds a sequence number, two class flags (held non-speculative, store), a set of physical source-register indices with ready bits, and two state flags (issued, squashed-in-queue). When a squash arrives with a boundary sequence number, the walker starts at the most recently written slot and moves one slot per clock toward older slots. It keeps going as long as the record in hand is younger than the boundary.

On each visited record that is still waiting, the block takes one of two actions. An ordinary record announces which of its unready, in-range sources must leave their register waiter lists. A held non-speculative or store record announces that its holding-table entry is to be discarded. In both cases the record is marked squashed and its sequence number is pushed toward the squashed pool, from which it later drains through issue. A stop control ends the squash, clears the boundary and drops the walk pointer. Three counters record entries examined, operands examined and held records dropped.

Top module: `squash_walker`

## Requirements
- R1: After reset, `busy` is 0, `boundary` is 0, all three counters are 0 and every bit of `sqFlags` is 0.
- R2: A request (`sqReq`=1, `sqSeq`≠0, `sqStop`=0) while idle loads `boundary` and raises `busy` from the next cycle. In the first busy cycle `walkSlot` is the youngest written slot. Each later busy cycle moves it one slot older, modulo DEPTH.
- R3: The walk ends with a busy cycle that takes no action. That happens on the first visited slot that has never been written, or whose sequence number is at or below the boundary, or after DEPTH slots have been visited. `busy` is 0 in the following cycle. No push or drop ever occurs while `busy` is 0.
- R4: A visited record that is already issued or already squashed is counted as examined, but it produces no push, no drop and no unlink.
- R5: A visited waiting record that is neither held nor a store pulses `poolPush`. Bit i of `unlinkMask` is 1 exactly when source i is not ready and its index is below NUM_PREGS. Field i of `unlinkRegs` (bits i*PREG_W upward) then carries that index, and is 0 otherwise. `cntOperands` grows by NUM_SRC.
- R6: A visited waiting record flagged held or store pulses `dropValid` and `poolPush` with its sequence number on `dropSeq` and `poolSeq`. `unlinkMask` stays 0 and `cntDropped` grows by 1.
- R7: Every pushed record has its `sqFlags` bit set from the next cycle.
- R8: `cntExamined` grows by exactly one for each visited record whose sequence number is above the boundary.
- R9: `sqStop` takes priority over every other input. It takes no action in its cycle, and from the next cycle `busy` and `boundary` are both 0.
- R10: A request with `sqSeq`=0 is ignored. A request while `busy` is 1 is ignored.
- R11: An insert while idle writes slot `tail`, clears that slot's flags and advances `tail` modulo DEPTH; `tail` is 0 after reset. An insert is ignored while busy or in a cycle that accepts a request. `issValid` marks a written slot `issSlot` as issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Write a new record |
| insSeq | input | SEQ_W | Sequence number of new record |
| insNonSpec | input | 1 | New record is held non-speculative |
| insStore | input | 1 | New record is a store |
| insSrcIdx | input | NUM_SRC*PREG_W | Source register indices, field i at i*PREG_W |
| insSrcRdy | input | NUM_SRC | Source ready bits |
| issValid | input | 1 | Mark a slot issued |
| issSlot | input | log2(DEPTH) | Slot to mark issued |
| sqReq | input | 1 | Start a squash |
| sqSeq | input | SEQ_W | Boundary sequence number |
| sqStop | input | 1 | End the squash and clear the boundary |
| busy | output | 1 | Walk in progress |
| boundary | output | SEQ_W | Active boundary, 0 when none |
| walkSlot | output | log2(DEPTH) | Slot visited this cycle |
| poolPush | output | 1 | Record sent to the squashed pool |
| poolSeq | output | SEQ_W | Sequence number of pushed record |
| dropValid | output | 1 | Holding-table entry to be discarded |
| dropSeq | output | SEQ_W | Sequence number of dropped record |
| unlinkMask | output | NUM_SRC | Sources to remove from waiter lists |
| unlinkRegs | output | NUM_SRC*PREG_W | Register index of each unlinked source |
| sqFlags | output | DEPTH | Squashed-in-queue flag per slot |
| cntExamined | output | CNT_W | Records visited above boundary |
| cntOperands | output | CNT_W | Source operands examined |
| cntDropped | output | CNT_W | Held records dropped |

## Verification
The first walk covers an issued youngest record, an ordinary record with one source index just past the register count, a store and a held record, and ends on the boundary comparison. This separates the skip, unlink and drop paths. A second walk with a low boundary revisits records that are already squashed and runs into a never-written slot, so the invalid-slot stop is told apart from the sequence stop. After the ring wraps, a third walk finds every slot younger than the boundary and can only end through the DEPTH limit. During these walks, zero-boundary requests, requests and inserts arriving mid-walk, and a stop arriving mid-walk show whether those inputs leak into the walk.

// File: rtl/squash_walk_pkg.sv
package squash_walk_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // accept request: latch boundary, point at youngest
    logic step;     // visit current slot and move older
    logic handle;   // current record is waiting: squash it
    logic special;  // handled record is held or store
    logic finish;   // walk ended this cycle
    logic stop;     // abandon and clear
  } walkStrobe_t;

  // Status from datapath to control about the current slot
  typedef struct packed {
    logic hit;      // written, younger than boundary, steps remain
    logic live;     // not issued, not already squashed
    logic special;  // held non-speculative or store
  } walkStatus_t;

endpackage

// File: rtl/squash_walk_ctrl.sv
module squash_walk_ctrl
  import squash_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sqReq,
  input  logic        sqSeqNz,
  input  logic        sqStop,
  input  walkStatus_t status,
  output walkStrobe_t strb,
  output logic        busy
);

  logic busyQ;

  always_comb begin
    strb         = '0;
    strb.stop    = sqStop;
    strb.load    = !sqStop && !busyQ && sqReq && sqSeqNz;
    strb.step    = !sqStop && busyQ && status.hit;
    strb.handle  = strb.step && status.live;
    strb.special = strb.handle && status.special;
    strb.finish  = !sqStop && busyQ && !status.hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busyQ <= 1'b0;
    else if (strb.stop)   busyQ <= 1'b0;
    else if (strb.load)   busyQ <= 1'b1;
    else if (strb.finish) busyQ <= 1'b0;
  end

  assign busy = busyQ;

  // R2
  start_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sqReq && sqSeqNz && !sqStop && !busy) |=> busy);

  // R10
  zero_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sqReq && !sqSeqNz && !busy) |=> !busy);

endmodule

// File: rtl/squash_walk_path.sv
module squash_walk_path
  import squash_walk_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int NUM_SRC   = 2,
  parameter int PREG_W    = 6,
  parameter int NUM_PREGS = 48,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  walkStrobe_t                 strb,
  input  logic                        busy,
  input  logic                        insValid,
  input  logic [SEQ_W-1:0]            insSeq,
  input  logic                        insNonSpec,
  input  logic                        insStore,
  input  logic [NUM_SRC*PREG_W-1:0]   insSrcIdx,
  input  logic [NUM_SRC-1:0]          insSrcRdy,
  input  logic                        issValid,
  input  logic [$clog2(DEPTH)-1:0]    issSlot,
  input  logic [SEQ_W-1:0]            sqSeq,
  output walkStatus_t                 status,
  output logic [SEQ_W-1:0]            boundary,
  output logic [$clog2(DEPTH)-1:0]    walkSlot,
  output logic                        poolPush,
  output logic [SEQ_W-1:0]            poolSeq,
  output logic                        dropValid,
  output logic [SEQ_W-1:0]            dropSeq,
  output logic [NUM_SRC-1:0]          unlinkMask,
  output logic [NUM_SRC*PREG_W-1:0]   unlinkRegs,
  output logic [DEPTH-1:0]            sqFlags,
  output logic [CNT_W-1:0]            cntExamined,
  output logic [CNT_W-1:0]            cntOperands,
  output logic [CNT_W-1:0]            cntDropped
);

  localparam int SLOT_W = $clog2(DEPTH);
  localparam int STEP_W = $clog2(DEPTH + 1);

  // record storage
  logic [DEPTH-1:0]              entValid, entIss, entSq, entNs, entSt;
  logic [SEQ_W-1:0]              entSeq [DEPTH];
  logic [NUM_SRC*PREG_W-1:0]     entSrc [DEPTH];
  logic [NUM_SRC-1:0]            entRdy [DEPTH];

  // walk state
  logic [SLOT_W-1:0] tail, walkPtr;
  logic              walkOn;
  logic [STEP_W-1:0] stepsLeft;
  logic [SEQ_W-1:0]  bndQ;

  logic insAccept;
  assign insAccept = insValid && !busy && !strb.load;

  // current slot status
  assign status.hit     = walkOn && entValid[walkPtr] && (entSeq[walkPtr] > bndQ)
                          && (stepsLeft != '0);
  assign status.live    = !entIss[walkPtr] && !entSq[walkPtr];
  assign status.special = entNs[walkPtr] || entSt[walkPtr];

  // per-source unlink decision
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic [PREG_W-1:0] srcIdx;
    logic              inRange;
    assign srcIdx  = entSrc[walkPtr][i*PREG_W +: PREG_W];
    assign inRange = {1'b0, srcIdx} < (PREG_W + 1)'(NUM_PREGS);
    assign unlinkMask[i] = strb.handle && !strb.special && !entRdy[walkPtr][i] && inRange;
    assign unlinkRegs[i*PREG_W +: PREG_W] = unlinkMask[i] ? srcIdx : '0;
  end

  assign poolPush  = strb.handle;
  assign poolSeq   = strb.handle ? entSeq[walkPtr] : '0;
  assign dropValid = strb.special;
  assign dropSeq   = strb.special ? entSeq[walkPtr] : '0;
  assign boundary  = bndQ;
  assign walkSlot  = walkPtr;
  assign sqFlags   = entSq;

  // record table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entIss   <= '0;
      entSq    <= '0;
      entNs    <= '0;
      entSt    <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        entSeq[s] <= '0;
        entSrc[s] <= '0;
        entRdy[s] <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (insAccept && tail == SLOT_W'(s)) begin
          entValid[s] <= 1'b1;
          entIss[s]   <= 1'b0;
          entSq[s]    <= 1'b0;
          entNs[s]    <= insNonSpec;
          entSt[s]    <= insStore;
          entSeq[s]   <= insSeq;
          entSrc[s]   <= insSrcIdx;
          entRdy[s]   <= insSrcRdy;
        end else begin
          if (issValid && issSlot == SLOT_W'(s) && entValid[s]) entIss[s] <= 1'b1;
          if (strb.handle && walkPtr == SLOT_W'(s))             entSq[s]  <= 1'b1;
        end
      end
    end
  end

  // walk pointer, boundary, tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tail      <= '0;
      walkPtr   <= '0;
      walkOn    <= 1'b0;
      stepsLeft <= '0;
      bndQ      <= '0;
    end else begin
      if (insAccept) tail <= tail + 1'b1;
      if (strb.stop) begin
        bndQ   <= '0;
        walkOn <= 1'b0;
      end else if (strb.load) begin
        bndQ      <= sqSeq;
        walkPtr   <= tail - 1'b1;
        walkOn    <= 1'b1;
        stepsLeft <= STEP_W'(DEPTH);
      end else if (strb.step) begin
        walkPtr   <= walkPtr - 1'b1;
        stepsLeft <= stepsLeft - 1'b1;
      end
    end
  end

  // statistics
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntExamined <= '0;
      cntOperands <= '0;
      cntDropped  <= '0;
    end else begin
      if (strb.step)                     cntExamined <= cntExamined + 1'b1;
      if (strb.handle && !strb.special)  cntOperands <= cntOperands + CNT_W'(NUM_SRC);
      if (strb.special)                  cntDropped  <= cntDropped + 1'b1;
    end
  end

  // R2
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (boundary != '0));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!poolPush && !dropValid && unlinkMask == '0));

  // R6
  drop_nounlink_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropValid |-> (poolPush && unlinkMask == '0));

  // R7
  pool_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    poolPush |=> sqFlags[$past(walkSlot)]);

  // R8
  exam_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntExamined == $past(cntExamined) || cntExamined == $past(cntExamined) + 1'b1));

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stop |=> (boundary == '0 && !busy));

endmodule

// File: rtl/squash_walker.sv
module squash_walker
  import squash_walk_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int NUM_SRC   = 2,
  parameter int PREG_W    = 6,
  parameter int NUM_PREGS = 48,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        insValid,
  input  logic [SEQ_W-1:0]            insSeq,
  input  logic                        insNonSpec,
  input  logic                        insStore,
  input  logic [NUM_SRC*PREG_W-1:0]   insSrcIdx,
  input  logic [NUM_SRC-1:0]          insSrcRdy,
  input  logic                        issValid,
  input  logic [$clog2(DEPTH)-1:0]    issSlot,
  input  logic                        sqReq,
  input  logic [SEQ_W-1:0]            sqSeq,
  input  logic                        sqStop,
  output logic                        busy,
  output logic [SEQ_W-1:0]            boundary,
  output logic [$clog2(DEPTH)-1:0]    walkSlot,
  output logic                        poolPush,
  output logic [SEQ_W-1:0]            poolSeq,
  output logic                        dropValid,
  output logic [SEQ_W-1:0]            dropSeq,
  output logic [NUM_SRC-1:0]          unlinkMask,
  output logic [NUM_SRC*PREG_W-1:0]   unlinkRegs,
  output logic [DEPTH-1:0]            sqFlags,
  output logic [CNT_W-1:0]            cntExamined,
  output logic [CNT_W-1:0]            cntOperands,
  output logic [CNT_W-1:0]            cntDropped
);

  walkStrobe_t strb;
  walkStatus_t status;

  squash_walk_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sqReq   (sqReq),
    .sqSeqNz (sqSeq != '0),
    .sqStop  (sqStop),
    .status  (status),
    .strb    (strb),
    .busy    (busy)
  );

  squash_walk_path #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .NUM_SRC(NUM_SRC),
    .PREG_W(PREG_W), .NUM_PREGS(NUM_PREGS), .CNT_W(CNT_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .insValid   (insValid),
    .insSeq     (insSeq),
    .insNonSpec (insNonSpec),
    .insStore   (insStore),
    .insSrcIdx  (insSrcIdx),
    .insSrcRdy  (insSrcRdy),
    .issValid   (issValid),
    .issSlot    (issSlot),
    .sqSeq      (sqSeq),
    .status     (status),
    .boundary   (boundary),
    .walkSlot   (walkSlot),
    .poolPush   (poolPush),
    .poolSeq    (poolSeq),
    .dropValid  (dropValid),
    .dropSeq    (dropSeq),
    .unlinkMask (unlinkMask),
    .unlinkRegs (unlinkRegs),
    .sqFlags    (sqFlags),
    .cntExamined(cntExamined),
    .cntOperands(cntOperands),
    .cntDropped (cntDropped)
  );

endmodule

// File: tb/squash_walker_test.sv
module squash_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int NS = 2;
  localparam int PW = 6;
  localparam int NP = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 0, insNonSpec = 0, insStore = 0, issValid = 0, sqReq = 0, sqStop = 0;
  logic [15:0] insSeq = '0, sqSeq = '0;
  logic [NS*PW-1:0] insSrcIdx = '0;
  logic [NS-1:0] insSrcRdy = '0;
  logic [2:0] issSlot = '0;
  logic busy, poolPush, dropValid;
  logic [15:0] boundary, poolSeq, dropSeq, cntExamined, cntOperands, cntDropped;
  logic [2:0] walkSlot;
  logic [NS-1:0] unlinkMask;
  logic [NS*PW-1:0] unlinkRegs;
  logic [D-1:0] sqFlags;

  always #(CLK_PERIOD/2) clk = ~clk;

  squash_walker uut (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model state
  int mSeq[D]; int mSrc[D][NS];
  bit mV[D], mI[D], mS[D], mNs[D], mSt[D], mR[D][NS];
  int mTail, mPtr, mSteps, mBound, mEx, mOp, mDr;
  bit mBusy;

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < D; s++) begin
      mV[s] = 0; mI[s] = 0; mS[s] = 0; mNs[s] = 0; mSt[s] = 0; mSeq[s] = 0;
      for (int i = 0; i < NS; i++) begin mSrc[s][i] = 0; mR[s][i] = 0; end
    end
    mTail = 0; mPtr = 0; mSteps = 0; mBound = 0; mEx = 0; mOp = 0; mDr = 0; mBusy = 0;
  endtask

  // compare outputs against model, then advance model and clock
  task automatic tick();
    bit hit, live, spec, push, load;
    int flags, mask, regs;
    #1;
    hit  = mBusy && mV[mPtr] && (mSeq[mPtr] > mBound) && (mSteps > 0);
    live = !mI[mPtr] && !mS[mPtr];
    spec = mNs[mPtr] || mSt[mPtr];
    push = hit && live && !sqStop;
    mask = 0; regs = 0; flags = 0;
    for (int i = 0; i < NS; i++)
      if (push && !spec && !mR[mPtr][i] && mSrc[mPtr][i] < NP) begin
        mask |= (1 << i);
        regs |= (mSrc[mPtr][i] << (i*PW));
      end
    for (int s = 0; s < D; s++) flags |= (int'(mS[s]) << s);
    chk("R2 R3 R9 busy", busy, mBusy);
    chk("R2 R9 boundary", boundary, mBound);
    if (mBusy) chk("R2 walkSlot", walkSlot, mPtr);
    chk("R4 R7 poolPush", poolPush, push);
    chk("R7 poolSeq", poolSeq, push ? mSeq[mPtr] : 0);
    chk("R6 dropValid", dropValid, push && spec);
    chk("R6 dropSeq", dropSeq, (push && spec) ? mSeq[mPtr] : 0);
    chk("R5 unlinkMask", unlinkMask, mask);
    chk("R5 unlinkRegs", unlinkRegs, regs);
    chk("R7 sqFlags", sqFlags, flags);
    chk("R8 cntExamined", cntExamined, mEx);
    chk("R5 cntOperands", cntOperands, mOp);
    chk("R6 cntDropped", cntDropped, mDr);
    // next state
    load = !sqStop && !mBusy && sqReq && (sqSeq != 0);
    if (mBusy && !sqStop && hit) begin
      mEx++;
      if (live) begin
        mS[mPtr] = 1;
        if (spec) mDr++; else mOp += NS;
      end
      mPtr = (mPtr + D - 1) % D;
      mSteps--;
    end
    if (issValid && mV[issSlot]) mI[issSlot] = 1;
    if (insValid && !mBusy && !load) begin
      mV[mTail] = 1; mI[mTail] = 0; mS[mTail] = 0;
      mNs[mTail] = insNonSpec; mSt[mTail] = insStore; mSeq[mTail] = insSeq;
      for (int i = 0; i < NS; i++) begin
        mSrc[mTail][i] = insSrcIdx[i*PW +: PW];
        mR[mTail][i] = insSrcRdy[i];
      end
      mTail = (mTail + 1) % D;
    end
    if (sqStop) begin mBusy = 0; mBound = 0; end
    else if (load) begin mBusy = 1; mBound = sqSeq; mPtr = (mTail + D - 1) % D; mSteps = D; end
    else if (mBusy && !hit) mBusy = 0;
    @(negedge clk);
  endtask

  task automatic doInsert(int seq, bit ns, bit st, int s0, bit r0, int s1, bit r1);
    insValid = 1; insSeq = 16'(seq); insNonSpec = ns; insStore = st;
    insSrcIdx = {PW'(s1), PW'(s0)}; insSrcRdy = {r1, r0};
    tick();
    insValid = 0; insNonSpec = 0; insStore = 0;
  endtask

  task automatic doSquash(int b);
    sqReq = 1; sqSeq = 16'(b); tick(); sqReq = 0; sqSeq = '0;
  endtask

  task automatic doStop();
    sqStop = 1; tick(); sqStop = 0;
  endtask

  task automatic runIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 40) begin cyc++; tick(); end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cyc;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 boundary", boundary, 0);
    chk("R1 counters", cntExamined + cntOperands + cntDropped, 0);
    chk("R1 sqFlags", sqFlags, 0);

    // R11 fill slots 0..5
    doInsert(10, 0, 0, 3, 0, 7, 1);
    doInsert(20, 0, 0, 8, 0, 9, 0);
    doInsert(30, 1, 0, 4, 0, 6, 0);
    doInsert(40, 0, 1, 2, 0, 1, 0);
    doInsert(50, 0, 0, 50, 0, 5, 0);
    doInsert(60, 0, 0, 11, 0, 12, 0);
    issValid = 1; issSlot = 3'd5; tick(); issValid = 0;   // R4 youngest issued

    // first walk: slots 5,4,3,2 then boundary stop at slot 1
    doSquash(25);
    runIdle(cyc);
    chk("R3 busy cycles boundary stop", cyc, 5);
    chk("R8 examined after walk one", cntExamined, 4);
    chk("R6 dropped after walk one", cntDropped, 2);
    doStop();
    chk("R9 boundary cleared", boundary, 0);

    // R10 zero boundary ignored
    doSquash(0);
    chk("R10 zero boundary busy", busy, 0);

    // second walk: stops at never-written slot 7; mid-walk request and insert ignored
    doSquash(5);
    tick();
    sqReq = 1; sqSeq = 16'd100; insValid = 1; insSeq = 16'd999; tick();
    sqReq = 0; sqSeq = '0; insValid = 0;
    chk("R10 boundary kept mid-walk", boundary, 5);
    runIdle(cyc);
    chk("R3 walk ends at unwritten slot", cntExamined, 10);
    doStop();

    // wrap: slots 6,7,0,1
    doInsert(100, 0, 0, 63, 0, 47, 0);
    doInsert(110, 0, 0, 20, 1, 21, 0);
    doInsert(120, 1, 1, 0, 0, 0, 0);
    doInsert(130, 0, 0, 30, 0, 31, 1);
    doSquash(5);
    chk("R11 walk starts at wrapped youngest slot", walkSlot, 1);
    runIdle(cyc);
    chk("R3 DEPTH-limited walk busy cycles", cyc, 9);
    doStop();

    // stop during a walk
    doInsert(200, 0, 0, 13, 0, 14, 0);
    doSquash(50);
    tick();
    sqStop = 1; tick(); sqStop = 0;
    chk("R9 busy dropped by stop", busy, 0);
    chk("R9 boundary zero after stop", boundary, 0);
    repeat (3) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule